// File: doc/BRIEF.md
# Three-Wire Codec Control Bus Master

This block is the controlling side of a three-wire serial control bus (bus clock, bus data, framing mode line) used to program the registers of an audio codec. A host hands it an address byte, a data byte count and, for writes, data bytes through a valid/ready pair; the master frames one address phase followed by zero or more data phases. For reads it releases the data line after the address byte and returns each received byte with a one-cycle valid pulse.

Every interval on the bus is counted in system clock cycles from runtime inputs: clock low time, clock high time, setup before a byte, hold after a byte, and a halt interval that separates consecutive data bytes. The halt interval is an extra clock-low pulse inserted before every data byte except the first, which is what sets this bus apart from a plain shift register interface. The mode line is held low while the address byte is on the wire and high while data bytes are.

Top module: `cbus_master`

## Requirements
- R1: Out of reset and after every transaction the bus clock, mode line and data output enable are low and busy_o is low.
- R2: A start_i pulse while idle raises busy_o and, in the following cycle, drives bus clock, mode, data and data output enable all high for exactly one cycle.
- R3: The address byte is sent first, least significant bit first, as 8 bus clock rising edges with the mode line low; the data line carries each bit at the rising edge.
- R4: Each bit holds the bus clock low for t_low_i cycles, then high for t_high_i cycles; the data output changes only while the bus clock is low during a transaction.
- R5: The bus clock stays high for t_setup_i cycles before each byte's first bit and t_hold_i cycles after its last bit (after the one-cycle start state for the address byte).
- R6: Every data byte after the first is preceded by a halt: the bus clock is held low for t_halt_i cycles and then returns high for the setup time.
- R7: In a write (rw_i=0) each data byte is taken from wdata_i in a cycle where wdata_ready_o and wdata_valid_i are both high; wdata_ready_o is high only while busy, between bytes, and data bits are sent with the mode line high, LSB first.
- R8: In a read (rw_i=1) the data output enable is low for all of the data phases; each bit is sampled in the last low cycle of the bus clock, and each byte (first received bit in bit 0) appears on rdata_o with a single-cycle rdata_valid_o pulse.
- R9: len_i (0 to 15) sets the number of data bytes; 0 gives an address-only transaction.
- R10: start_i and the request inputs are ignored while busy_o is high.
- R11: A timing input of zero behaves as a count of one.
- R12: During a transaction the mode line changes only while the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transaction (idle only) |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 8 | Address byte |
| len_i | input | 4 | Number of data bytes |
| wdata_i | input | 8 | Write data byte |
| wdata_valid_i | input | 1 | Write data valid |
| wdata_ready_o | output | 1 | Master accepts a write byte |
| rdata_o | output | 8 | Read data byte |
| rdata_valid_o | output | 1 | One-cycle pulse per read byte |
| busy_o | output | 1 | Transaction in progress |
| t_low_i | input | 8 | Bus clock low cycles per bit |
| t_high_i | input | 8 | Bus clock high cycles per bit |
| t_setup_i | input | 8 | Cycles before a byte's bits |
| t_hold_i | input | 8 | Cycles after a byte's bits |
| t_halt_i | input | 8 | Halt low cycles between data bytes |
| bus_clk_o | output | 1 | Bus clock |
| bus_mode_o | output | 1 | Bus framing mode line |
| bus_dat_o | output | 1 | Bus data output value |
| bus_dat_oe_o | output | 1 | Bus data output enable |
| bus_dat_i | input | 1 | Bus data input |

## Verification
The assertions watch, on every cycle, that the lines rest low when idle, that the start state drives all lines high, that data and mode edges fall only in the permitted clock phase, that the write handshake appears only mid-transaction and that read pulses last one cycle while the latched direction cannot change under a running transfer. The exact cycle counts of low, high, setup, hold and halt intervals, the placement of halt pulses, bit order on the wire, byte counts and the bytes returned by a modelled slave with a pull-up can only be shown by the bench's directed transfers.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SETUP,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_HOLD,
    ST_FETCH,
    ST_HALT
  } cbus_state_e;
endpackage

// File: rtl/cbus_timer.sv
module cbus_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= (val_i == '0) ? '0 : val_i - 1'b1;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/cbus_shifter.sv
module cbus_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         in_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else if (load_i) q_q <= load_val_i;
    else if (shift_i) q_q <= {in_i, q_q[W-1:1]};
  end

  assign q_o = q_q;
endmodule

// File: rtl/cbus_master.sv
module cbus_master
  import cbus_pkg::*;
#(
  parameter int CW     = 8,
  parameter int LW     = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [LW-1:0]     len_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wdata_valid_i,
  output logic              wdata_ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic              busy_o,
  input  logic [CW-1:0]     t_low_i,
  input  logic [CW-1:0]     t_high_i,
  input  logic [CW-1:0]     t_setup_i,
  input  logic [CW-1:0]     t_hold_i,
  input  logic [CW-1:0]     t_halt_i,
  output logic              bus_clk_o,
  output logic              bus_mode_o,
  output logic              bus_dat_o,
  output logic              bus_dat_oe_o,
  input  logic              bus_dat_i
);
  localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

  cbus_state_e state_q, state_d;
  logic              is_addr_q, rd_q, first_q, dat_q, rvalid_q;
  logic [LW-1:0]     rem_q, bytes_left;
  logic [BCW-1:0]    bit_q;
  logic [DATA_W-1:0] rdata_q, sh_q, sh_load_val;
  logic [CW-1:0]     dur;
  logic              t_done, t_load, sh_load, tx_shift, rx_shift;
  logic              hold_end, wr_dir;

  assign wr_dir     = is_addr_q | ~rd_q;
  assign bytes_left = is_addr_q ? rem_q : rem_q - 1'b1;
  assign hold_end   = (state_q == ST_HOLD) && t_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_START;
      ST_START:  state_d = ST_SETUP;
      ST_SETUP:  if (t_done) state_d = ST_BIT_LO;
      ST_BIT_LO: if (t_done) state_d = ST_BIT_HI;
      ST_BIT_HI: if (t_done) state_d = (bit_q == LAST_BIT) ? ST_HOLD : ST_BIT_LO;
      ST_HOLD: begin
        if (t_done) begin
          if (bytes_left == '0) state_d = ST_IDLE;
          else if (!rd_q)       state_d = ST_FETCH;
          else                  state_d = is_addr_q ? ST_SETUP : ST_HALT;
        end
      end
      ST_FETCH:  if (wdata_valid_i) state_d = first_q ? ST_SETUP : ST_HALT;
      ST_HALT:   if (t_done) state_d = ST_SETUP;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_SETUP:  dur = t_setup_i;
      ST_BIT_LO: dur = t_low_i;
      ST_BIT_HI: dur = t_high_i;
      ST_HOLD:   dur = t_hold_i;
      ST_HALT:   dur = t_halt_i;
      default:   dur = '0;
    endcase
  end

  assign t_load = (state_d != state_q);

  cbus_timer #(.CW(CW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (dur),
    .done_o (t_done)
  );

  // write bits leave at BIT_LO entry; read bits enter at BIT_LO exit
  assign sh_load     = ((state_q == ST_IDLE) && start_i) ||
                       ((state_q == ST_FETCH) && wdata_valid_i);
  assign sh_load_val = (state_q == ST_IDLE) ? addr_i : wdata_i;
  assign tx_shift    = t_load && (state_d == ST_BIT_LO) && wr_dir;
  assign rx_shift    = (state_q == ST_BIT_LO) && t_done && !wr_dir;

  cbus_shifter #(.W(DATA_W)) i_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sh_load),
    .load_val_i (sh_load_val),
    .shift_i    (tx_shift | rx_shift),
    .in_i       (rx_shift & bus_dat_i),
    .q_o        (sh_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      is_addr_q <= 1'b0;
      rd_q      <= 1'b0;
      first_q   <= 1'b0;
      rem_q     <= '0;
      bit_q     <= '0;
      dat_q     <= 1'b0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= hold_end && !is_addr_q && rd_q;
      if ((state_q == ST_IDLE) && start_i) begin
        rd_q      <= rw_i;
        rem_q     <= len_i;
        is_addr_q <= 1'b1;
        first_q   <= 1'b1;
        dat_q     <= 1'b1;
      end
      if (t_load && (state_d == ST_SETUP)) bit_q <= '0;
      else if ((state_q == ST_BIT_HI) && t_done) bit_q <= bit_q + 1'b1;
      if (tx_shift) dat_q <= sh_q[0];
      else if (t_load && (state_d == ST_IDLE)) dat_q <= 1'b0;
      if (hold_end) begin
        if (is_addr_q) is_addr_q <= 1'b0;
        else begin
          rem_q   <= rem_q - 1'b1;
          first_q <= 1'b0;
          if (rd_q) rdata_q <= sh_q;
        end
      end
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign bus_clk_o     = !((state_q == ST_IDLE) || (state_q == ST_BIT_LO) ||
                           (state_q == ST_HALT));
  assign bus_mode_o    = (state_q == ST_START) || (busy_o && !is_addr_q);
  assign bus_dat_o     = dat_q;
  assign bus_dat_oe_o  = busy_o && wr_dir;
  assign wdata_ready_o = (state_q == ST_FETCH);
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;
endmodule

// File: rtl/cbus_master_chk.sv
module cbus_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic bus_clk_o,
  input logic bus_mode_o,
  input logic bus_dat_o,
  input logic bus_dat_oe_o,
  input logic wdata_ready_o,
  input logic rdata_valid_o,
  input logic rd_q
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!bus_clk_o && !bus_mode_o && !bus_dat_oe_o)); // R1

  AST_START_ALL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && bus_clk_o && bus_mode_o && bus_dat_o && bus_dat_oe_o)); // R2

  AST_DATA_MOVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$stable(bus_dat_o)) |-> !bus_clk_o); // R4

  AST_READY_MID_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_ready_o |-> (busy_o && bus_mode_o && bus_clk_o && bus_dat_oe_o)); // R7

  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |=> !rdata_valid_o); // R8

  AST_DIR_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rd_q)); // R10

  AST_MODE_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$stable(bus_mode_o)) |-> (bus_clk_o && $past(bus_clk_o))); // R12
endmodule

bind cbus_master cbus_master_chk i_cbus_master_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .bus_clk_o     (bus_clk_o),
  .bus_mode_o    (bus_mode_o),
  .bus_dat_o     (bus_dat_o),
  .bus_dat_oe_o  (bus_dat_oe_o),
  .wdata_ready_o (wdata_ready_o),
  .rdata_valid_o (rdata_valid_o),
  .rd_q          (rd_q)
);

// File: tb/test_cbus_master.sv
module test_cbus_master;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       rw_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [3:0] len_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wdata_valid_i = 1'b0;
  logic       wdata_ready_o;
  logic [7:0] rdata_o;
  logic       rdata_valid_o;
  logic       busy_o;
  logic [7:0] t_low_i = 8'd3, t_high_i = 8'd2, t_setup_i = 8'd4, t_hold_i = 8'd2, t_halt_i = 8'd5;
  logic       bus_clk_o, bus_mode_o, bus_dat_o, bus_dat_oe_o, bus_dat_i;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cbus_master i_cbus_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rw_i(rw_i),
    .addr_i(addr_i), .len_i(len_i), .wdata_i(wdata_i),
    .wdata_valid_i(wdata_valid_i), .wdata_ready_o(wdata_ready_o),
    .rdata_o(rdata_o), .rdata_valid_o(rdata_valid_o), .busy_o(busy_o),
    .t_low_i(t_low_i), .t_high_i(t_high_i), .t_setup_i(t_setup_i),
    .t_hold_i(t_hold_i), .t_halt_i(t_halt_i),
    .bus_clk_o(bus_clk_o), .bus_mode_o(bus_mode_o), .bus_dat_o(bus_dat_o),
    .bus_dat_oe_o(bus_dat_oe_o), .bus_dat_i(bus_dat_i)
  );

  // slave model and bus monitor
  logic       rd_mode = 1'b0;
  logic [7:0] wb [16];
  logic [7:0] rb [16];
  logic [7:0] acap;
  logic [7:0] wcap [16];
  logic [7:0] rcap [16];
  int low_len [256];
  int high_len [256];
  int n_a, n_d, n_r, n_f, n_rv, lowrun, highrun, oe_viol, mode_bad, mq;
  logic pbusy = 1'b0, pclk = 1'b0, pmode = 1'b0;
  logic sbit;
  int sq;

  always_comb begin
    sq = n_d + 1;
    if (sq % 9 == 0) sbit = 1'b1;
    else sbit = rb[(sq / 9) % 16][(sq % 9) - 1];
  end

  assign bus_dat_i = bus_dat_oe_o ? bus_dat_o : ((rd_mode && bus_mode_o) ? sbit : 1'b1);

  always @(negedge clk_i) begin
    if (busy_o && !pbusy) begin
      n_a = 0; n_d = 0; n_r = 0; n_f = 0; n_rv = 0;
      lowrun = 0; highrun = 1; oe_viol = 0; mode_bad = 0; acap = '0;
    end else if (pbusy) begin
      if (bus_clk_o && !pclk) begin
        if (n_r < 256) low_len[n_r] = lowrun;
        n_r++;
        if (!bus_mode_o) begin
          if (n_a < 8) acap[n_a] = bus_dat_o;
          n_a++;
        end else begin
          mq = n_d + 1;
          if (mq % 9 != 0) wcap[(mq / 9) % 16][(mq % 9) - 1] = bus_dat_o;
          n_d++;
        end
        highrun = 1;
      end else if (!bus_clk_o && pclk) begin
        if (n_f < 256) high_len[n_f] = highrun;
        n_f++;
        lowrun = 1;
      end else if (bus_clk_o) highrun++;
      else lowrun++;
      if (busy_o && rd_mode && bus_mode_o && bus_dat_oe_o && n_a >= 8) oe_viol++;
      if (busy_o && (bus_mode_o != pmode) && !(bus_clk_o && pclk)) mode_bad++;
    end
    if (rdata_valid_o) begin
      if (n_rv < 16) rcap[n_rv] = rdata_o;
      n_rv++;
    end
    pbusy = busy_o; pclk = bus_clk_o; pmode = bus_mode_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one transaction; ign_at > 0 pulses a conflicting start at that loop step
  task automatic do_xfer(input logic rw, input logic [7:0] a, input int n, input int ign_at);
    int widx = 0;
    bit st_ok;
    rd_mode = rw;
    wdata_i = wb[0];
    wdata_valid_i = !rw;
    @(negedge clk_i);
    start_i = 1'b1; rw_i = rw; addr_i = a; len_i = n[3:0];
    @(negedge clk_i);
    start_i = 1'b0;
    st_ok = busy_o && bus_clk_o && bus_mode_o && bus_dat_o && bus_dat_oe_o;
    chk(st_ok, "R2 start state all high", int'(st_ok), 1);
    for (int k = 0; k < 100000; k++) begin
      @(negedge clk_i);
      if (!busy_o) break;
      if (ign_at > 0) begin
        if (k == ign_at) begin
          start_i = 1'b1; rw_i = ~rw; addr_i = 8'h99; len_i = 4'd5;
        end else start_i = 1'b0;
      end
      if (wdata_ready_o && wdata_valid_i) begin
        @(posedge clk_i); #1;
        widx++;
        wdata_i = wb[widx % 16];
      end
    end
    start_i = 1'b0;
    wdata_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(!busy_o && !bus_clk_o && !bus_mode_o && !bus_dat_oe_o, "R1 reset lines low",
        int'({busy_o, bus_clk_o, bus_mode_o, bus_dat_oe_o}), 0);
    chk(!wdata_ready_o && !rdata_valid_o, "R1 reset handshake low",
        int'({wdata_ready_o, rdata_valid_o}), 0);
  endtask

  task automatic t_write;
    wb[0] = 8'hA5; wb[1] = 8'h3C; wb[2] = 8'h81;
    do_xfer(1'b0, 8'h14, 3, 0);
    chk(acap == 8'h14, "R3 address bits", int'(acap), 8'h14);
    chk(n_a == 8, "R3 address rises", n_a, 8);
    chk(low_len[0] == 3, "R4 bit low time", low_len[0], 3);
    chk(high_len[1] == 2, "R4 bit high time", high_len[1], 2);
    chk(high_len[0] == 5, "R5 start plus setup", high_len[0], 5);
    chk(high_len[8] == 9, "R5 high+hold+fetch+setup", high_len[8], 9);
    chk(low_len[16] == 5, "R6 halt low time", low_len[16], 5);
    chk(high_len[17] == 4, "R6 setup after halt", high_len[17], 4);
    for (int j = 0; j < 3; j++)
      chk(wcap[j] == wb[j], "R7 write byte", int'(wcap[j]), int'(wb[j]));
    chk(n_d == 26, "R9 data rises for 3 bytes", n_d, 26);
    chk(mode_bad == 0, "R12 mode edges with clock high", mode_bad, 0);
    chk(!bus_clk_o && !bus_mode_o && !bus_dat_oe_o, "R1 lines low after end",
        int'({bus_clk_o, bus_mode_o, bus_dat_oe_o}), 0);
  endtask

  task automatic t_read;
    rb[0] = 8'h6B; rb[1] = 8'hD2;
    do_xfer(1'b1, 8'h15, 2, 0);
    @(negedge clk_i);
    chk(acap == 8'h15, "R3 read address bits", int'(acap), 8'h15);
    chk(n_rv == 2, "R8 read valid pulses", n_rv, 2);
    chk(rcap[0] == 8'h6B, "R8 read byte 0", int'(rcap[0]), 8'h6B);
    chk(rcap[1] == 8'hD2, "R8 read byte 1", int'(rcap[1]), 8'hD2);
    chk(oe_viol == 0, "R8 data released in read", oe_viol, 0);
    chk(high_len[8] == 8, "R5 high+hold+setup read", high_len[8], 8);
    chk(low_len[16] == 5, "R6 read halt low time", low_len[16], 5);
    chk(mode_bad == 0, "R12 read mode edges", mode_bad, 0);
  endtask

  task automatic t_addr_only;
    do_xfer(1'b0, 8'hE1, 0, 0);
    chk(acap == 8'hE1, "R9 address-only address", int'(acap), 8'hE1);
    chk(n_d == 0, "R9 address-only no data", n_d, 0);
  endtask

  task automatic t_zero;
    t_low_i = 0; t_high_i = 0; t_setup_i = 0; t_hold_i = 0; t_halt_i = 0;
    wb[0] = 8'hC3;
    do_xfer(1'b0, 8'h7E, 1, 0);
    chk(low_len[0] == 1, "R11 zero low acts as one", low_len[0], 1);
    chk(high_len[1] == 1, "R11 zero high acts as one", high_len[1], 1);
    chk(high_len[0] == 2, "R11 zero setup acts as one", high_len[0], 2);
    chk(wcap[0] == 8'hC3 && acap == 8'h7E, "R11 zero counts data", int'(wcap[0]), 8'hC3);
    t_low_i = 8'd3; t_high_i = 8'd2; t_setup_i = 8'd4; t_hold_i = 8'd2; t_halt_i = 8'd5;
  endtask

  task automatic t_ignore;
    bit seen = 1'b0;
    wb[0] = 8'h5A;
    do_xfer(1'b0, 8'h22, 1, 20);
    chk(acap == 8'h22, "R10 address kept", int'(acap), 8'h22);
    chk(n_d == 8 && wcap[0] == 8'h5A, "R10 transfer unchanged", n_d, 8);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_i);
      if (busy_o) seen = 1'b1;
    end
    chk(!seen, "R10 no second transaction", int'(seen), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_write();
    t_read();
    t_addr_only();
    t_zero();
    t_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule